// File: doc/BRIEF.md
# Product-Term Cluster Allocator

This block is one slice of a programmable sum-of-products fabric. A set of array inputs feeds a group of AND terms. Each term can pick any input in true or inverted form. The terms are grouped into one cluster per macrocell. Each cluster has a basic part and one extra term. The basic part holds four terms when its home macrocell is configured synchronous and two when it is asynchronous. The extra term is used in one of two ways. It can join the cluster's sum. Or it can act as the second operand of the home macrocell's output XOR. When the extra term joins the sum, that XOR operand is a programmable constant instead, which sets the output polarity.

A steering field decides where each cluster goes: to its home macrocell, to the neighbour just below, to the neighbour just above, or nowhere. A macrocell ORs every cluster that reaches it. The result then passes through that macrocell's XOR.

All configuration sits in one long serial shift register, loaded while a load enable is high. The outputs are the combinational values that would feed the macrocell registers. They are forced to zero for as long as loading is in progress.

Top module: `pt_alloc_slice`

## Requirements
- R1: A term ANDs every input whose true-select bit is set with the inversion of every input whose complement-select bit is set. A term with no select bits set evaluates to 0.
- R2: When a macrocell's mode bit is 1 (synchronous), its cluster's basic sum is the OR of terms 0 to 3.
- R3: When a macrocell's mode bit is 0 (asynchronous), only terms 0 and 1 enter its basic sum. Terms 2 and 3 have no effect on any output.
- R4: The number of terms in a cluster is set by the mode bit of the cluster's home macrocell, even when the cluster is steered to a macrocell with a different mode.
- R5: When a macrocell's extra-role bit is 0, term 4 of its cluster is ORed into the cluster sum. The macrocell output is then its received sum XOR its polarity bit.
- R6: When a macrocell's extra-role bit is 1, term 4 stays out of the cluster sum. The macrocell output is then its received sum XOR its own term 4, and the polarity bit has no effect.
- R7: Steering codes: 0 sends the cluster to its home macrocell, 1 to the macrocell with index one lower, and 2 to the macrocell with index one higher. Code 3, or a move past either end of the slice, drops the cluster. A macrocell ORs all clusters it receives.
- R8: A macrocell that receives no cluster has a sum of 0. Its output therefore equals its XOR operand.
- R9: While the load enable is high, each clock shifts the configuration vector up by one bit and enters the serial input at bit 0. While the load enable is low, the configuration holds. Macrocell m occupies bits starting at m*(5+10*N_IN). Within that field: bit 0 is the mode, bits 2:1 are the steering code, bit 3 is the extra role, and bit 4 is the polarity. Term t uses a true-select mask at offset 5+t*2*N_IN and a complement-select mask at N_IN bits above that, with bit i of each mask selecting input i.
- R10: While the load enable is high, every macrocell output is 0.
- R11: Reset clears the whole configuration, so every output is 0 after reset whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load_en | input | 1 | Shift enable for the configuration register |
| cfg_sdi | input | 1 | Serial configuration data |
| arr_in | input | N_IN | Inputs to the product-term array |
| mc_out | output | N_MC | Per-macrocell sum after the XOR stage |

## Verification
The bench builds the slice with N_IN = 6 and the default 8 macrocells. A configuration is then 520 bits long, so dozens of configurations can be loaded within the run. Every one of the 64 input patterns can also be applied exhaustively to each configuration. Six inputs are few enough that randomly drawn sparse masks often make terms true. This brings OR merging of several clusters, edge drops and XOR polarity effects within reach, which would be rare with 33 inputs. Eight macrocells still give interior nodes, which can receive from both sides, as well as both edges.

// File: rtl/pt_alloc_pkg.sv
package pt_alloc_pkg;
  // steering code of a cluster
  typedef enum logic [1:0] {
    RT_HOME = 2'd0,
    RT_DOWN = 2'd1,
    RT_UP   = 2'd2,
    RT_OFF  = 2'd3
  } route_e;

  // per-macrocell header field positions
  localparam int F_MODE  = 0;
  localparam int F_ROUTE = 1;
  localparam int F_XSEL  = 3;
  localparam int F_POL   = 4;
  localparam int HDR_W   = 5;
endpackage

// File: rtl/pt_and_term.sv
module pt_and_term #(
  parameter int N_IN = 33
) (
  input  logic [N_IN-1:0] lits,
  input  logic [N_IN-1:0] tsel,
  input  logic [N_IN-1:0] csel,
  output logic            term
);
  logic used;
  logic t_ok;
  logic c_ok;

  always_comb begin
    used = |{tsel, csel};
    t_ok = ((lits & tsel) == tsel);
    c_ok = ((~lits & csel) == csel);
    // an unprogrammed term must not pull a sum high
    term = used & t_ok & c_ok;
  end
endmodule

// File: rtl/pt_cluster.sv
module pt_cluster #(
  parameter int N_IN    = 33,
  parameter int N_SYNC  = 4,
  parameter int N_ASYNC = 2,
  localparam int LIT_W  = 2 * N_IN,
  localparam int N_TERM = N_SYNC + 1
) (
  input  logic [N_IN-1:0]         lits,
  input  logic [N_TERM*LIT_W-1:0] masks,
  input  logic                    mode_sync,
  input  logic                    xsel,
  output logic                    clu_sum,
  output logic                    xtra
);
  logic [N_TERM-1:0] terms;
  logic [N_SYNC-1:0] basic_en;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pt_and_term #(.N_IN(N_IN)) u_term (
      .lits (lits),
      .tsel (masks[t*LIT_W +: N_IN]),
      .csel (masks[t*LIT_W + N_IN +: N_IN]),
      .term (terms[t])
    );
  end

  // size of the basic cluster follows the home macrocell mode
  for (genvar t = 0; t < N_SYNC; t++) begin : g_en
    if (t < N_ASYNC) begin : g_always
      assign basic_en[t] = 1'b1;
    end else begin : g_sync_only
      assign basic_en[t] = mode_sync;
    end
  end

  always_comb begin
    xtra    = terms[N_SYNC];
    clu_sum = |(terms[N_SYNC-1:0] & basic_en) | (xtra & ~xsel);
  end
endmodule

// File: rtl/pt_router.sv
module pt_router
  import pt_alloc_pkg::*;
#(
  parameter int N_MC = 8
) (
  input  logic [N_MC-1:0][1:0] route,
  input  logic [N_MC-1:0]      clu_sum,
  output logic [N_MC-1:0]      presum
);
  for (genvar d = 0; d < N_MC; d++) begin : g_dst
    logic from_home;
    logic from_below;
    logic from_above;

    assign from_home = clu_sum[d] & (route[d] == RT_HOME);

    if (d > 0) begin : g_below
      assign from_below = clu_sum[d-1] & (route[d-1] == RT_UP);
    end else begin : g_no_below
      assign from_below = 1'b0;
    end

    if (d < N_MC - 1) begin : g_above
      assign from_above = clu_sum[d+1] & (route[d+1] == RT_DOWN);
    end else begin : g_no_above
      assign from_above = 1'b0;
    end

    assign presum[d] = from_home | from_below | from_above;
  end
endmodule

// File: rtl/pt_alloc_slice.sv
module pt_alloc_slice
  import pt_alloc_pkg::*;
#(
  parameter int N_IN    = 33,
  parameter int N_MC    = 8,
  parameter int N_SYNC  = 4,
  parameter int N_ASYNC = 2,
  localparam int LIT_W  = 2 * N_IN,
  localparam int N_TERM = N_SYNC + 1,
  localparam int MC_W   = HDR_W + N_TERM * LIT_W,
  localparam int CFG_W  = N_MC * MC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load_en,
  input  logic            cfg_sdi,
  input  logic [N_IN-1:0] arr_in,
  output logic [N_MC-1:0] mc_out
);
  logic [CFG_W-1:0]       cfg_q;
  logic [CFG_W-1:0]       cfg_d;
  logic [N_MC-1:0]        mode_v;
  logic [N_MC-1:0][1:0]   route_v;
  logic [N_MC-1:0]        xsel_v;
  logic [N_MC-1:0]        pol_v;
  logic [N_MC-1:0]        clu_sum;
  logic [N_MC-1:0]        xtra_v;
  logic [N_MC-1:0]        presum;
  logic [N_MC-1:0]        out_raw;
  logic [N_MC-1:0]        hit;

  // configuration shift register: next state
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_load_en) begin
      cfg_d = {cfg_q[CFG_W-2:0], cfg_sdi};
    end
  end

  // configuration shift register: state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_load_en) begin
      cfg_q <= cfg_d;
    end
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam int B = m * MC_W;

    assign mode_v[m]  = cfg_q[B + F_MODE];
    assign route_v[m] = cfg_q[B + F_ROUTE +: 2];
    assign xsel_v[m]  = cfg_q[B + F_XSEL];
    assign pol_v[m]   = cfg_q[B + F_POL];

    pt_cluster #(
      .N_IN    (N_IN),
      .N_SYNC  (N_SYNC),
      .N_ASYNC (N_ASYNC)
    ) u_clu (
      .lits      (arr_in),
      .masks     (cfg_q[B + HDR_W +: N_TERM*LIT_W]),
      .mode_sync (mode_v[m]),
      .xsel      (xsel_v[m]),
      .clu_sum   (clu_sum[m]),
      .xtra      (xtra_v[m])
    );
  end

  pt_router #(.N_MC(N_MC)) u_rtr (
    .route   (route_v),
    .clu_sum (clu_sum),
    .presum  (presum)
  );

  // XOR stage and load gating
  always_comb begin
    for (int m = 0; m < N_MC; m++) begin
      out_raw[m] = presum[m] ^ (xsel_v[m] ? xtra_v[m] : pol_v[m]);
    end
    mc_out = cfg_load_en ? '0 : out_raw;
  end

  // which macrocells some cluster is steered to, seen from the sources
  always_comb begin
    hit = '0;
    for (int s = 0; s < N_MC; s++) begin
      case (route_v[s])
        RT_HOME: hit[s] = 1'b1;
        RT_DOWN: if (s > 0) hit[s-1] = 1'b1;
        RT_UP:   if (s < N_MC - 1) hit[s+1] = 1'b1;
        default: ;
      endcase
    end
  end

  p_load_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_en |-> (mc_out == '0));

  p_shift_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_en |=> (cfg_q[0] == $past(cfg_sdi)));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_en |=> (cfg_q == $past(cfg_q)));

  for (genvar m = 0; m < N_MC; m++) begin : g_chk
    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[m] |-> !presum[m]);

    p_xor_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load_en && xsel_v[m] && !hit[m]) |-> (mc_out[m] == xtra_v[m]));
  end
endmodule

// File: tb/pt_alloc_slice_tb.sv
module pt_alloc_slice_tb;
  localparam int NI  = 6;
  localparam int NM  = 8;
  localparam int NT  = 5;
  localparam int LW  = 2 * NI;
  localparam int MW  = 5 + NT * LW;
  localparam int CW  = NM * MW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load_en;
  logic          cfg_sdi;
  logic [NI-1:0] arr_in;
  logic [NM-1:0] mc_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  bit          m_mode [NM];
  bit [1:0]    m_route[NM];
  bit          m_xsel [NM];
  bit          m_pol  [NM];
  bit [NI-1:0] m_t    [NM][NT];
  bit [NI-1:0] m_c    [NM][NT];

  always #4 clk = ~clk;

  pt_alloc_slice #(.N_IN(NI), .N_MC(NM)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load_en (cfg_load_en),
    .cfg_sdi     (cfg_sdi),
    .arr_in      (arr_in),
    .mc_out      (mc_out)
  );

  function automatic bit term_val(int m, int t, bit [NI-1:0] p);
    if ((m_t[m][t] | m_c[m][t]) == '0) return 1'b0;
    return ((p & m_t[m][t]) == m_t[m][t]) && ((~p & m_c[m][t]) == m_c[m][t]);
  endfunction

  function automatic bit [NM-1:0] model(bit [NI-1:0] p);
    bit [NM-1:0] sum = '0;
    bit [NM-1:0] res;
    for (int m = 0; m < NM; m++) begin
      int  nb = m_mode[m] ? 4 : 2;
      bit  cs = 1'b0;
      for (int t = 0; t < nb; t++) cs |= term_val(m, t, p);
      if (!m_xsel[m]) cs |= term_val(m, 4, p);
      if (m_route[m] == 2'd0) sum[m] |= cs;
      else if (m_route[m] == 2'd1 && m > 0) sum[m-1] |= cs;
      else if (m_route[m] == 2'd2 && m < NM - 1) sum[m+1] |= cs;
    end
    for (int m = 0; m < NM; m++)
      res[m] = sum[m] ^ (m_xsel[m] ? term_val(m, 4, p) : m_pol[m]);
    return res;
  endfunction

  function automatic bit [CW-1:0] pack_cfg();
    bit [CW-1:0] v = '0;
    for (int m = 0; m < NM; m++) begin
      int b = m * MW;
      v[b]        = m_mode[m];
      v[b+1 +: 2] = m_route[m];
      v[b+3]      = m_xsel[m];
      v[b+4]      = m_pol[m];
      for (int t = 0; t < NT; t++) begin
        v[b + 5 + t*LW +: NI]      = m_t[m][t];
        v[b + 5 + t*LW + NI +: NI] = m_c[m][t];
      end
    end
    return v;
  endfunction

  task automatic check(string req, logic [NM-1:0] act, logic [NM-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: mc_out=%b expected=%b (arr_in=%b)", req, act, exp, arr_in);
    end
  endtask

  task automatic clear_cfg();
    for (int m = 0; m < NM; m++) begin
      m_mode[m] = 0; m_route[m] = 2'd0; m_xsel[m] = 0; m_pol[m] = 0;
      for (int t = 0; t < NT; t++) begin m_t[m][t] = '0; m_c[m][t] = '0; end
    end
  endtask

  task automatic rand_cfg();
    for (int m = 0; m < NM; m++) begin
      m_mode[m]  = 1'($urandom);
      m_route[m] = 2'($urandom);
      m_xsel[m]  = 1'($urandom);
      m_pol[m]   = 1'($urandom);
      for (int t = 0; t < NT; t++)
        for (int i = 0; i < NI; i++) begin
          m_t[m][t][i] = ($urandom % 5) == 0;
          m_c[m][t][i] = ($urandom % 5) == 0;
        end
    end
  endtask

  // shift in MSB first; outputs must read 0 throughout (R10)
  task automatic load_cfg();
    bit [CW-1:0] v = pack_cfg();
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_load_en = 1'b1;
      cfg_sdi     = v[i];
      arr_in      = NI'($urandom);
      #1 check("R10", mc_out, '0);
    end
    @(negedge clk);
    cfg_load_en = 1'b0;
  endtask

  // all input patterns; serial input toggles while idle (R9 hold)
  task automatic sweep(string req);
    for (int p = 0; p < (1 << NI); p++) begin
      @(negedge clk);
      cfg_sdi = 1'($urandom);
      arr_in  = NI'(p);
      #1 check(req, mc_out, model(NI'(p)));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_load_en = 1'b0; cfg_sdi = 1'b0; arr_in = '0;
    clear_cfg();
    repeat (3) @(negedge clk);
    arr_in = '1;
    #1 check("R11", mc_out, '0);
    rst_n = 1'b1;
    sweep("R11");

    // R1: true literal, then complement literal, on home macrocell 0
    clear_cfg();
    m_t[0][0] = 6'b000101;
    m_c[1][0] = 6'b000010;
    m_t[2][1] = 6'b000001; m_c[2][1] = 6'b000001;
    load_cfg(); sweep("R1");

    // R2: synchronous cluster uses terms 2 and 3
    clear_cfg();
    m_mode[3] = 1; m_t[3][2] = 6'b000011; m_c[3][3] = 6'b110000;
    load_cfg(); sweep("R2");

    // R3: asynchronous cluster ignores terms 2 and 3
    clear_cfg();
    m_mode[3] = 0; m_t[3][2] = 6'b000001; m_c[3][3] = 6'b000001;
    m_t[3][1] = 6'b100000;
    load_cfg(); sweep("R3");

    // R4: async home steered into sync neighbour keeps the small size
    clear_cfg();
    m_mode[3] = 0; m_route[3] = 2'd2; m_t[3][2] = 6'b000001;
    m_t[3][0] = 6'b001000;
    m_mode[4] = 1; m_route[4] = 2'd3;
    m_mode[6] = 1; m_route[6] = 2'd1; m_t[6][3] = 6'b010000;
    m_mode[5] = 0; m_route[5] = 2'd3;
    load_cfg(); sweep("R4");

    // R5: extra term joins sum, polarity inverts
    clear_cfg();
    m_t[1][4] = 6'b000011; m_pol[1] = 1;
    m_t[2][4] = 6'b000100; m_t[2][0] = 6'b001000;
    load_cfg(); sweep("R5");

    // R6: extra term drives XOR, polarity ignored
    clear_cfg();
    m_xsel[5] = 1; m_pol[5] = 1; m_t[5][4] = 6'b000011; m_t[5][0] = 6'b000001;
    m_xsel[6] = 1; m_pol[6] = 1; m_c[6][4] = 6'b100000;
    load_cfg(); sweep("R6");

    // R7: edge drops, code 3 drop, two clusters merging into one macrocell
    clear_cfg();
    m_route[0] = 2'd1; m_t[0][0] = 6'b000001;
    m_route[7] = 2'd2; m_t[7][0] = 6'b000010;
    m_route[1] = 2'd3; m_t[1][0] = 6'b000100;
    m_route[2] = 2'd2; m_t[2][0] = 6'b001000;
    m_route[4] = 2'd1; m_t[4][1] = 6'b010000;
    m_route[3] = 2'd0; m_c[3][0] = 6'b100000;
    load_cfg(); sweep("R7");

    // R8: empty macrocells show their XOR operand
    clear_cfg();
    for (int m = 0; m < NM; m++) begin m_route[m] = 2'd3; m_pol[m] = m[0]; end
    m_t[4][0] = 6'b000001;
    load_cfg(); sweep("R8");

    // R9: random configurations, exhaustive inputs each
    for (int k = 0; k < 18; k++) begin
      rand_cfg();
      load_cfg(); sweep("R9");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule